// File: doc/BRIEF.md
# Gigabit Ethernet Lane Sync Monitor

This block sits after an 8b/10b decoder and comma detector on one receive lane. It takes one decoded code group per clock, given as three flags: an enable that says a group is present, a flag that says the group decoded without error, and a flag that says the group carries a comma. From these flags it decides whether the lane is synchronized. It drives a sync status output that is high while the lane is locked and low otherwise.

While the lane is unsynchronized, the block hunts for lock. Lock is declared after three comma groups, each followed by a valid data group, with no invalid group anywhere in the sequence. While locked, the block keeps an error credit. Each invalid group adds one to the credit, and a run of four valid groups removes one. A single bad group therefore does not drop the lane, but a burst of bad groups does. The credit value is brought out as a debug output. Decoding, comma detection and bit slipping are done upstream.

Top module: `lane_sync_monitor`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `sync_ok` is 0 and `err_cnt` is 0.
- R2: While unsynchronized, a valid group with `grp_comma`=1 opens a pair, and the next valid group with `grp_comma`=0 closes it. When the third pair closes, `sync_ok` goes to 1 at the next clock edge. A valid non-comma group that arrives while no pair is open is ignored. A repeated valid comma that arrives while a pair is open keeps that pair open.
- R3: While unsynchronized, a group with `grp_valid`=0 discards any pairs already counted, so acquisition starts again from zero pairs.
- R4: When lock is acquired, `err_cnt` is set to 0 and the run of valid groups starts again from zero.
- R5: While synchronized, each group with `grp_valid`=0 raises `err_cnt` by one at the next edge.
- R6: While synchronized, every fourth consecutive valid group lowers `err_cnt` by one. `err_cnt` never goes below 0, and the run restarts from zero after each fourth group.
- R7: While synchronized, an invalid group resets the run of consecutive valid groups to zero.
- R8: When `err_cnt` reaches 4, `sync_ok` drops to 0 at that same edge. `err_cnt` then holds at 4 until lock is acquired again.
- R9: A clock with `grp_en`=0 changes neither `sync_ok`, nor `err_cnt`, nor the progress of acquisition or of the valid run.
- R10: After lock is lost, a new lock again needs three complete pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one code group per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_en | input | 1 | A code group is present this cycle |
| grp_valid | input | 1 | 1 = the group decoded without error, 0 = invalid group |
| grp_comma | input | 1 | 1 = the group carries a comma |
| sync_ok | output | 1 | 1 = lane synchronized |
| err_cnt | output | $clog2(ERR_LIMIT+1) | Debug view of the error credit |

## Verification
Acquisition is driven with clean comma/data pairs, with stray data before the first comma, and with an invalid group in the middle of a sequence. These patterns separate a correct pair counter from one that counts commas alone or that fails to restart. While locked, an isolated error followed by exactly three and then four valid groups pins the decay point of the credit. An error placed inside a valid run shows whether the run is cleared. Errors spaced two valid groups apart show that the credit, and not a consecutive-error count, causes the loss. Gaps with the enable low, placed in both the locked and the hunting states, show that an idle cycle leaves all progress unchanged.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    typedef enum logic {
        LINK_HUNT   = 1'b0,
        LINK_LOCKED = 1'b1
    } link_state_e;

    typedef enum logic {
        WANT_COMMA = 1'b0,
        WANT_DATA  = 1'b1
    } acq_phase_e;
endpackage

// File: rtl/lsm_acquire.sv
module lsm_acquire
    import lsm_pkg::*;
#(
    parameter int PAIRS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grp_en,
    input  logic grp_valid,
    input  logic grp_comma,
    input  logic hunting,
    output logic acq_hit
);
    localparam int PW = $clog2(PAIRS + 1);
    localparam logic [PW-1:0] LAST_PAIR = PW'(PAIRS - 1);

    typedef struct packed {
        acq_phase_e    phase;
        logic [PW-1:0] pairs;
    } acq_t;

    localparam acq_t ACQ_IDLE = '{phase: WANT_COMMA, pairs: '0};

    acq_t acq_d, acq_q;

    always_comb begin
        acq_d   = acq_q;
        acq_hit = 1'b0;
        if (!hunting) begin
            acq_d = ACQ_IDLE;
        end else if (grp_en) begin
            if (!grp_valid) begin
                // R3: an invalid group throws away any pairs counted so far
                acq_d = ACQ_IDLE;
            end else begin
                case (acq_q.phase)
                    WANT_COMMA: begin
                        if (grp_comma) acq_d.phase = WANT_DATA;
                    end
                    WANT_DATA: begin
                        if (!grp_comma) begin
                            if (acq_q.pairs == LAST_PAIR) begin
                                acq_hit = 1'b1;
                                acq_d   = ACQ_IDLE;
                            end else begin
                                acq_d.pairs = acq_q.pairs + 1'b1;
                                acq_d.phase = WANT_COMMA;
                            end
                        end
                    end
                    default: acq_d = ACQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acq_q <= ACQ_IDLE;
        else        acq_q <= acq_d;
    end
endmodule

// File: rtl/lsm_err_credit.sv
module lsm_err_credit #(
    parameter int ERR_LIMIT = 4,
    parameter int GOOD_RUN  = 4,
    localparam int EW = $clog2(ERR_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grp_en,
    input  logic          grp_valid,
    input  logic          active,
    input  logic          clear,
    output logic [EW-1:0] err_cnt,
    output logic          lose_hit
);
    localparam int RW = $clog2(GOOD_RUN + 1);
    localparam logic [EW-1:0] ERR_EDGE = EW'(ERR_LIMIT - 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(GOOD_RUN - 1);

    typedef struct packed {
        logic [EW-1:0] err;
        logic [RW-1:0] run;
    } credit_t;

    credit_t cr_d, cr_q;

    always_comb begin
        cr_d     = cr_q;
        lose_hit = 1'b0;
        if (clear) begin
            cr_d = '0;
        end else if (active && grp_en) begin
            if (!grp_valid) begin
                cr_d.run = '0;
                cr_d.err = cr_q.err + 1'b1;
                if (cr_q.err == ERR_EDGE) lose_hit = 1'b1;
            end else if (cr_q.run == RUN_LAST) begin
                cr_d.run = '0;
                if (cr_q.err != '0) cr_d.err = cr_q.err - 1'b1;
            end else begin
                cr_d.run = cr_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cr_q <= '0;
        else        cr_q <= cr_d;
    end

    assign err_cnt = cr_q.err;
endmodule

// File: rtl/lane_sync_monitor.sv
module lane_sync_monitor
    import lsm_pkg::*;
#(
    parameter int ACQ_PAIRS = 3,
    parameter int ERR_LIMIT = 4,
    parameter int GOOD_RUN  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           grp_en,
    input  logic                           grp_valid,
    input  logic                           grp_comma,
    output logic                           sync_ok,
    output logic [$clog2(ERR_LIMIT+1)-1:0] err_cnt
);
    typedef struct packed {
        link_state_e state;
    } link_t;

    link_t lk_d, lk_q;
    logic  hunting;
    logic  acq_hit;
    logic  lose_hit;

    assign hunting = (lk_q.state == LINK_HUNT);

    lsm_acquire #(.PAIRS(ACQ_PAIRS)) u_acq (
        .clk      (clk),
        .rst_n    (rst_n),
        .grp_en   (grp_en),
        .grp_valid(grp_valid),
        .grp_comma(grp_comma),
        .hunting  (hunting),
        .acq_hit  (acq_hit)
    );

    lsm_err_credit #(.ERR_LIMIT(ERR_LIMIT), .GOOD_RUN(GOOD_RUN)) u_credit (
        .clk      (clk),
        .rst_n    (rst_n),
        .grp_en   (grp_en),
        .grp_valid(grp_valid),
        .active   (!hunting),
        .clear    (acq_hit),
        .err_cnt  (err_cnt),
        .lose_hit (lose_hit)
    );

    always_comb begin
        lk_d = lk_q;
        case (lk_q.state)
            LINK_HUNT:   if (acq_hit)  lk_d.state = LINK_LOCKED;
            LINK_LOCKED: if (lose_hit) lk_d.state = LINK_HUNT;
            default:                   lk_d.state = LINK_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '{state: LINK_HUNT};
        else        lk_q <= lk_d;
    end

    assign sync_ok = (lk_q.state == LINK_LOCKED);
endmodule

// File: rtl/lsm_checker.sv
module lsm_checker #(
    parameter int ERR_LIMIT = 4,
    localparam int EW = $clog2(ERR_LIMIT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          grp_en,
    input logic          grp_valid,
    input logic          sync_ok,
    input logic [EW-1:0] err_cnt
);
    localparam logic [EW-1:0] LIM  = EW'(ERR_LIMIT);
    localparam logic [EW-1:0] EDGE = EW'(ERR_LIMIT - 1);

    p_err_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= LIM);

    p_err_rises_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ok && grp_en && !grp_valid && err_cnt < EDGE |=> err_cnt == $past(err_cnt) + 1'b1);

    p_loss_at_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ok && grp_en && !grp_valid && err_cnt == EDGE |=> !sync_ok && err_cnt == LIM);

    p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_en |=> $stable(sync_ok) && $stable(err_cnt));

    p_lock_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_ok) |-> err_cnt == '0);

    p_hunt_holds_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_ok |=> sync_ok || $stable(err_cnt));
endmodule

bind lane_sync_monitor lsm_checker #(.ERR_LIMIT(ERR_LIMIT)) u_lsm_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .grp_en   (grp_en),
    .grp_valid(grp_valid),
    .sync_ok  (sync_ok),
    .err_cnt  (err_cnt)
);

// File: tb/tb_lane_sync_monitor.sv
module tb_lane_sync_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       grp_en = 1'b0;
    logic       grp_valid = 1'b0;
    logic       grp_comma = 1'b0;
    logic       sync_ok;
    logic [2:0] err_cnt;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    lane_sync_monitor dut (
        .clk(clk), .rst_n(rst_n), .grp_en(grp_en), .grp_valid(grp_valid),
        .grp_comma(grp_comma), .sync_ok(sync_ok), .err_cnt(err_cnt)
    );

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // drive one group at a falling edge; return at the next falling edge
    task automatic put(logic en, logic v, logic c);
        grp_en = en; grp_valid = v; grp_comma = c;
        @(negedge clk);
        grp_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; grp_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pairs(int n);
        for (int i = 0; i < n; i++) begin
            put(1, 1, 1); put(1, 1, 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 sync in reset", sync_ok, 0);
        check("R1 err in reset", err_cnt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sync after release", sync_ok, 0);
        check("R1 err after release", err_cnt, 0);
    endtask

    task automatic t_acquire();
        do_reset();
        put(1, 1, 0); put(1, 1, 0);          // stray data, no comma yet
        put(1, 1, 1); put(1, 1, 1);          // repeated comma keeps pair open
        put(1, 1, 0);
        pairs(1);
        put(1, 1, 1);
        check("R2 not locked before third close", sync_ok, 0);
        put(1, 1, 0);
        check("R2 locked after third pair", sync_ok, 1);
        check("R4 err cleared on lock", err_cnt, 0);
    endtask

    task automatic t_acq_restart();
        do_reset();
        pairs(2);
        put(1, 0, 0);                        // invalid: restart
        pairs(2);
        check("R3 restart after invalid", sync_ok, 0);
        pairs(1);
        check("R3 lock after fresh three", sync_ok, 1);
    endtask

    task automatic t_inc_dec();
        do_reset(); pairs(3);
        put(1, 0, 0);
        check("R5 err up by one", err_cnt, 1);
        check("R5 still locked", sync_ok, 1);
        for (int i = 0; i < 3; i++) put(1, 1, 0);
        check("R6 no decay after three valid", err_cnt, 1);
        put(1, 1, 0);
        check("R6 decay after fourth valid", err_cnt, 0);
        for (int i = 0; i < 4; i++) put(1, 1, 0);
        check("R6 floor at zero", err_cnt, 0);
    endtask

    task automatic t_run_reset();
        do_reset(); pairs(3);
        put(1, 0, 0); put(1, 0, 0);
        check("R5 err two", err_cnt, 2);
        for (int i = 0; i < 3; i++) put(1, 1, 0);
        put(1, 0, 0);
        check("R7 run broken, err three", err_cnt, 3);
        for (int i = 0; i < 3; i++) put(1, 1, 0);
        check("R7 run restarted from zero", err_cnt, 3);
        put(1, 1, 0);
        check("R6 decay after full run", err_cnt, 2);
        check("R7 still locked", sync_ok, 1);
    endtask

    task automatic t_loss();
        do_reset(); pairs(3);
        put(1, 0, 0);
        for (int k = 0; k < 2; k++) begin
            put(1, 1, 0); put(1, 1, 0); put(1, 0, 0);
        end
        check("R8 locked at err three", sync_ok, 1);
        put(1, 1, 0); put(1, 1, 0); put(1, 0, 0);
        check("R8 loss at four", sync_ok, 0);
        check("R8 err shows limit", err_cnt, 4);
        for (int i = 0; i < 5; i++) put(1, 1, 0);
        check("R8 err holds while hunting", err_cnt, 4);
        pairs(2);
        check("R10 partial reacquire not locked", sync_ok, 0);
        pairs(1);
        check("R10 relock", sync_ok, 1);
        check("R4 err cleared on relock", err_cnt, 0);
    endtask

    task automatic t_enable();
        do_reset(); pairs(3);
        put(1, 0, 0);
        put(0, 0, 0); put(0, 0, 0);
        check("R9 idle invalid ignored", err_cnt, 1);
        for (int i = 0; i < 3; i++) put(1, 1, 0);
        put(0, 1, 0);
        check("R9 idle valid not counted in run", err_cnt, 1);
        put(1, 1, 0);
        check("R9 run resumes across gap", err_cnt, 0);
        do_reset();
        pairs(2); put(1, 1, 1);
        put(0, 0, 0); put(0, 1, 0);
        check("R9 idle no lock", sync_ok, 0);
        put(1, 1, 0);
        check("R9 acquisition kept across gap", sync_ok, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got 0 expected 1 (test completion)");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_acquire();
        t_acq_restart();
        t_inc_dec();
        t_run_reset();
        t_loss();
        t_enable();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule